// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps two 64-bit up-counting time bases (a main one and an alternate one) and a 32-bit down-counting decrementer. All three move on a shared single-cycle tick enable. A run input freezes both time bases while low and lets them continue from their held values when it returns high. The decrementer is not affected by the run input.

Software reaches the counters through a small synchronous register port. It can read and write each time base in 32-bit halves and the decrementer as a whole word. Reading the low half of a time base also captures its upper half, so a later read of the upper half returns a value that matches the low half even if a carry happened between the two reads. The decrementer raises a level interrupt request when it counts through zero. The request is also raised when software stores a negative value over a non-negative one. It stays asserted until software writes the acknowledge address.

Two static mode inputs change what software sees. One makes decrementer reads return zero once the count is negative. The other masks the low word of the main time base with 0x3FFFFF80 on both writes and reads, for real-time-clock style software.

Top module: `tbdec_unit`

## Requirements
- R1: A write to the low half of a time base leaves its upper half unchanged, and a write to the upper half leaves the low half unchanged. This holds for both time bases.
- R2: While run_en_i is high, each time base increments by one on every cycle with tick_i high and no register write. A carry out of the low half increments the upper half.
- R3: While run_en_i is low, both time bases hold their values. Once run_en_i is high again, they resume counting from the held values.
- R4: The decrementer decrements by one on each tick, whatever the level of run_en_i. A tick while it holds 0 loads 0xFFFFFFFF and sets the pending interrupt.
- R5: A decrementer write with bit 31 set, made while the current value has bit 31 clear, sets the pending interrupt in the same cycle. The same write made while the current value already has bit 31 set does not set it.
- R6: With clamp_i high, a decrementer read returns 0 whenever the value has bit 31 set. With clamp_i low, it returns the raw two's-complement value.
- R7: After reset, and after any write to the reload address (6), the decrementer holds 0xFFFFFFFF. The reload does not set the pending interrupt.
- R8: With rtc_mode_i high, writes and reads of the main time base low half (address 0) are ANDed with 0x3FFFFF80. The alternate time base is not masked.
- R9: irq_o stays high until a write to the acknowledge address (5). If an expiry falls in the same cycle as that write, the interrupt stays set.
- R10: A read of address 0 or 2 captures that base's upper half. A read of address 1 or 3 returns the captured value. rdata_o is valid in the cycle after rd_en_i.
- R11: Address map: 0 main low, 1 main high, 2 alternate low, 3 alternate high, 4 decrementer, 5 acknowledge (write only), 6 reload (write only). Reads of other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable shared by all counters |
| run_en_i | input | 1 | High lets the time bases count |
| clamp_i | input | 1 | Decrementer reads return 0 when negative |
| rtc_mode_i | input | 1 | Masks the main low word with 0x3FFFFF80 |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Pending decrementer interrupt |

## Verification
Writes, ticks and acknowledges all act at the same rising edge at which they are presented. The bench therefore samples irq_o at the falling edge that follows. Read data is registered, so each expected word is pushed into a queue when the read is issued. A monitor pops it at the falling edge one cycle later, using a bench-side copy of the read strobe delayed by one cycle. Ticks are held low during reads so that every expected value follows directly from the sequence of writes and tick counts.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [31:0] RTC_MASK = 32'h3FFF_FF80;

  typedef enum logic [ADDR_W-1:0] {
    A_TB_LO  = 3'd0,
    A_TB_HI  = 3'd1,
    A_ALT_LO = 3'd2,
    A_ALT_HI = 3'd3,
    A_DEC    = 3'd4,
    A_ACK    = 3'd5,
    A_RELOAD = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/tbdec_base.sv
module tbdec_base #(
  parameter int unsigned HALF_W = 32,
  localparam int unsigned FULL_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic [HALF_W-1:0] lo_mask_i,
  output logic [FULL_W-1:0] val_o
);
  logic [FULL_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (wr_lo_i) begin
      val_q <= {val_q[FULL_W-1:HALF_W], wdata_i & lo_mask_i};
    end else if (wr_hi_i) begin
      val_q <= {wdata_i, val_q[HALF_W-1:0]};
    end else if (cnt_en_i) begin
      val_q <= val_q + FULL_W'(1);
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/tbdec_dec.sv
module tbdec_dec #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         wr_dec_i,
  input  logic         wr_ack_i,
  input  logic         reload_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dec_o,
  output logic         irq_o
);
  logic [W-1:0] dec_q;
  logic         pend_q;
  logic         expire, neg_store;

  // counting through zero only when no store overrides the tick
  assign expire    = tick_i && !wr_dec_i && !reload_i && (dec_q == '0);
  assign neg_store = wr_dec_i && wdata_i[W-1] && !dec_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q <= '1;
    end else if (reload_i) begin
      dec_q <= '1;
    end else if (wr_dec_i) begin
      dec_q <= wdata_i;
    end else if (tick_i) begin
      dec_q <= dec_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (expire || neg_store) begin
      pend_q <= 1'b1;
    end else if (wr_ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign dec_o = dec_q;
  assign irq_o = pend_q;
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
  import tbdec_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter int unsigned N_BASE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_en_i,
  input  logic              clamp_i,
  input  logic              rtc_mode_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o
);
  logic [2*W-1:0] base_val [N_BASE];
  logic [W-1:0]   lo_mask  [N_BASE];
  logic [W-1:0]   hi_snap  [N_BASE];
  logic [2*W-1:0] tb_val;
  logic [W-1:0]   dec_val;
  logic           any_wr;

  assign any_wr = wr_en_i;

  for (genvar g = 0; g < N_BASE; g++) begin : g_base
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en_i && (addr_i == ADDR_W'(2 * g));
    assign wr_hi = wr_en_i && (addr_i == ADDR_W'(2 * g + 1));
    // only the main base carries the clock-compatible mask
    if (g == 0) begin : g_mask
      assign lo_mask[g] = rtc_mode_i ? W'(RTC_MASK) : '1;
    end else begin : g_nomask
      assign lo_mask[g] = '1;
    end

    tbdec_base #(.HALF_W(W)) u_base (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cnt_en_i (tick_i && run_en_i && !any_wr),
      .wr_lo_i  (wr_lo),
      .wr_hi_i  (wr_hi),
      .wdata_i  (wdata_i),
      .lo_mask_i(lo_mask[g]),
      .val_o    (base_val[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_snap[g] <= '0;
      end else if (rd_en_i && addr_i == ADDR_W'(2 * g)) begin
        hi_snap[g] <= base_val[g][2*W-1:W];
      end
    end
  end

  assign tb_val = base_val[0];

  tbdec_dec #(.W(W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_dec_i(wr_en_i && addr_i == A_DEC),
    .wr_ack_i(wr_en_i && addr_i == A_ACK),
    .reload_i(wr_en_i && addr_i == A_RELOAD),
    .wdata_i (wdata_i),
    .dec_o   (dec_val),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        A_TB_LO:  rdata_o <= base_val[0][W-1:0] & lo_mask[0];
        A_TB_HI:  rdata_o <= hi_snap[0];
        A_ALT_LO: rdata_o <= base_val[1][W-1:0];
        A_ALT_HI: rdata_o <= hi_snap[1];
        A_DEC:    rdata_o <= (clamp_i && dec_val[W-1]) ? '0 : dec_val;
        default:  rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tbdec_chk.sv
module tbdec_chk
  import tbdec_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              run_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wmsb_i,
  input logic              irq_o,
  input logic [2*W-1:0]    tb_val,
  input logic [W-1:0]      dec_val
);
  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_i && tick_i && !wr_en_i) |=> tb_val == $past(tb_val) + 1);

  a_r3_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !wr_en_i) |=> $stable(tb_val));

  a_r4_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i && dec_val == '0) |=> (dec_val == '1 && irq_o));

  a_r5_neg_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_DEC && wmsb_i && !dec_val[W-1]) |=> irq_o);

  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_RELOAD) |=> dec_val == '1);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_en_i && addr_i == A_ACK)) |=> irq_o);
endmodule

bind tbdec_unit tbdec_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .run_en_i(run_en_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wmsb_i  (wdata_i[W-1]),
  .irq_o   (irq_o),
  .tb_val  (tb_val),
  .dec_val (dec_val)
);

// File: tb/tb_tbdec_unit.sv
module tb_tbdec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, run_en_i = 1'b1, clamp_i = 1'b0, rtc_mode_i = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d = 1'b0;
  bit          done = 0;

  tbdec_unit dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) rd_d <= rd_en_i;

  // monitor: read data is due one cycle after the strobe
  always @(negedge clk_i) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s rdata actual=%08h expected=%08h", t, rdata_o, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk_i);
    n_run++;
    if (irq_o !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq_o, e);
    end
  endtask

  initial begin
    #4_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    rd(0, 32'h0, "R10 reset lo");
    rd(1, 32'h0, "R10 reset hi");
    rd(4, 32'hFFFF_FFFF, "R7 reset dec");
    chk_irq(0, "R7 reset irq");
    // half writes
    wr(0, 32'hFFFF_FFFE);
    wr(1, 32'h0000_0001);
    rd(0, 32'hFFFF_FFFE, "R1 lo kept");
    rd(1, 32'h1, "R1 hi");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'hFFFF_FFFF, "R1 lo");
    rd(1, 32'h1, "R1 hi unchanged");
    // carry
    ticks(1);
    rd(0, 32'h0, "R2 carry lo");
    rd(1, 32'h2, "R2 carry hi");
    wr(3, 32'hABCD_0000);
    rd(2, 32'h1, "R1 alt lo kept");
    rd(3, 32'hABCD_0000, "R1 alt hi");
    // freeze and resume; decrementer keeps going
    run_en_i = 1'b0;
    ticks(5);
    rd(0, 32'h0, "R3 frozen main");
    rd(2, 32'h1, "R3 frozen alt");
    rd(4, 32'hFFFF_FFF9, "R4 dec ignores run");
    run_en_i = 1'b1;
    ticks(3);
    rd(0, 32'h3, "R3 resume main");
    rd(2, 32'h4, "R3 resume alt");
    // snapshot of upper half
    rd(0, 32'h3, "R10 snap lo");
    wr(1, 32'h55);
    rd(1, 32'h2, "R10 snap hi");
    rd(0, 32'h3, "R10 lo again");
    rd(1, 32'h55, "R10 new hi");
    // expiry
    wr(4, 32'h2);
    chk_irq(0, "R4 no irq yet");
    ticks(2);
    chk_irq(0, "R4 at zero");
    ticks(1);
    chk_irq(1, "R4 expiry");
    rd(4, 32'hFFFF_FFFF, "R4 wrap");
    chk_irq(1, "R9 held");
    wr(5, 32'h0);
    chk_irq(0, "R9 ack");
    // negative over negative, clamp
    wr(4, 32'h8000_0005);
    chk_irq(0, "R5 neg over neg");
    clamp_i = 1'b1;
    rd(4, 32'h0, "R6 clamp");
    clamp_i = 1'b0;
    rd(4, 32'h8000_0005, "R6 raw");
    wr(4, 32'h5);
    chk_irq(0, "R5 positive store");
    wr(4, 32'h8000_0000);
    chk_irq(1, "R5 neg store");
    wr(5, 32'h0);
    chk_irq(0, "R9 ack2");
    // expiry in the ack cycle
    wr(4, 32'h1);
    ticks(1);
    chk_irq(0, "R4 reach zero");
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'd5; tick_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
    chk_irq(1, "R9 expiry wins");
    rd(4, 32'hFFFF_FFFF, "R9 dec wrapped");
    wr(5, 32'h0);
    // reload
    wr(4, 32'h10);
    wr(6, 32'h0);
    rd(4, 32'hFFFF_FFFF, "R7 reload");
    chk_irq(0, "R7 reload no irq");
    // rtc mask
    rtc_mode_i = 1'b1;
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h3FFF_FF80, "R8 masked write");
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'hFFFF_FFFF, "R8 alt unmasked");
    rtc_mode_i = 1'b0;
    wr(0, 32'h1234_5678);
    rtc_mode_i = 1'b1;
    rd(0, 32'h1234_5600, "R8 masked read");
    rtc_mode_i = 1'b0;
    rd(0, 32'h1234_5678, "R8 unmasked read");
    rd(7, 32'h0, "R11 unused addr");
    repeat (3) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R10 %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule